// File: doc/BRIEF.md
# Open Page Tracking Unit

This block sits between address decoding and command timing checks in a DRAM controller. It keeps one entry for every bank of every rank. Each entry records whether the bank has a row open and, if so, which row. Every decoded request is looked up in this table and leaves the block one cycle later, tagged with the row commands that must come before its column command.

There are three outcomes. A hit on the open row needs nothing. A closed bank needs an activate. An open bank holding a different row needs a precharge and then an activate. Classifying a request does not change the table. Only notices from the command output stage do that: an issued activate opens a row, an issued precharge closes one bank, and a precharge-all closes every bank.

A notice that arrives in the same cycle as a lookup is applied before the lookup is classified. The tagged request then goes on to the timing-check stage.

Top module: `open_page_tracker`

## Requirements
- R1: While reset is asserted, and at its release, `out_valid_o` is 0 and every table entry is invalid. A first request to any bank after reset is tagged as needing an activate.
- R2: A request presented with `req_valid_i` high appears on the outputs in the next cycle with `out_valid_o` high. Rank, bank, row, column and the write flag are passed through unchanged. A cycle with no request gives `out_valid_o` low in the next cycle.
- R3: A request to a bank with no open row is tagged `out_need_o` = 2'b01 (activate only).
- R4: A request to a bank whose open row equals the request row is tagged `out_need_o` = 2'b00 (no row command).
- R5: A request to a bank whose open row differs from the request row is tagged `out_need_o` = 2'b11 (precharge then activate).
- R6: Classification never changes the table. Repeated requests to the same bank see the same state until a notice arrives.
- R7: An activate notice marks its rank/bank entry open with the notice row. A precharge notice marks that one entry closed. Entries of other banks are left unchanged.
- R8: A precharge-all notice marks every entry closed in a single cycle.
- R9: A notice and a lookup in the same cycle give a classification based on the table as updated by that notice.
- R10: If an activate notice coincides with a precharge or precharge-all notice, the activated bank ends up open with the new row. The precharge still applies to every other bank it covers.
- R11: `out_need_o` never takes the value 2'b10 while `out_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Decoded request present |
| req_rank_i | input | RANK_W | Request rank |
| req_bank_i | input | BANK_W | Request bank |
| req_row_i | input | ROW_W | Request row |
| req_col_i | input | COL_W | Request column |
| req_write_i | input | 1 | 1 = write, 0 = read |
| ntc_act_i | input | 1 | Activate issued to ntc_rank_i/ntc_bank_i, row ntc_row_i |
| ntc_pre_i | input | 1 | Precharge issued to ntc_rank_i/ntc_bank_i |
| ntc_pre_all_i | input | 1 | Precharge of all banks issued |
| ntc_rank_i | input | RANK_W | Notice rank |
| ntc_bank_i | input | BANK_W | Notice bank |
| ntc_row_i | input | ROW_W | Row opened by the activate notice |
| out_valid_o | output | 1 | Tagged request present |
| out_rank_o | output | RANK_W | Forwarded rank |
| out_bank_o | output | BANK_W | Forwarded bank |
| out_row_o | output | ROW_W | Forwarded row |
| out_col_o | output | COL_W | Forwarded column |
| out_write_o | output | 1 | Forwarded write flag |
| out_need_o | output | 2 | 00 none, 01 activate, 11 precharge then activate |

## Verification
There is one register between a request and its tag, so every result is due exactly one clock edge after the request. A notice takes effect on the edge that follows it. When a notice and a request share a cycle, the tag produced on that same edge must already reflect the notice.

The bench drives inputs on the falling edge and reads outputs on the next falling edge, which is half a cycle after the edge that produced them. Every notice is applied on its own cycle before the lookups that depend on it, except in the scenarios that deliberately put a notice and a lookup in the same cycle.

// File: rtl/opt_pkg.sv
package opt_pkg;
  typedef enum logic [1:0] {
    NEED_NONE    = 2'b00,
    NEED_ACT     = 2'b01,
    NEED_PRE_ACT = 2'b11
  } need_e;
endpackage

// File: rtl/opt_page_table.sv
module opt_page_table #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2,
  parameter int ROW_W   = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             pre_all_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic [ROW_W-1:0] upd_row_i,
  input  logic [IDX_W-1:0] lkp_idx_i,
  output logic             lkp_valid_o,
  output logic [ROW_W-1:0] lkp_row_o
);
  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [ROW_W-1:0]   row_q [ENTRIES];
  logic [ROW_W-1:0]   row_d [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic sel, set, clr;
    assign sel = (upd_idx_i == IDX_W'(e));
    assign set = act_i & sel;
    assign clr = pre_all_i | (pre_i & sel);

    // activate wins over a coincident precharge
    always_comb begin
      vld_d[e] = vld_q[e];
      row_d[e] = row_q[e];
      if (set) begin
        vld_d[e] = 1'b1;
        row_d[e] = upd_row_i;
      end else if (clr) begin
        vld_d[e] = 1'b0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[e] <= 1'b0;
        row_q[e] <= '0;
      end else begin
        vld_q[e] <= vld_d[e];
        row_q[e] <= row_d[e];
      end
    end
  end

  // lookup reads next state: same-cycle notice is visible
  always_comb begin
    lkp_valid_o = 1'b0;
    lkp_row_o   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkp_idx_i == IDX_W'(i)) begin
        lkp_valid_o = vld_d[i];
        lkp_row_o   = row_d[i];
      end
    end
  end
endmodule

// File: rtl/opt_classify.sv
module opt_classify
  import opt_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic             open_i,
  input  logic [ROW_W-1:0] open_row_i,
  input  logic [ROW_W-1:0] req_row_i,
  output need_e            need_o
);
  always_comb begin
    if (!open_i)                       need_o = NEED_ACT;
    else if (open_row_i == req_row_i)  need_o = NEED_NONE;
    else                               need_o = NEED_PRE_ACT;
  end
endmodule

// File: rtl/opt_out_stage.sv
module opt_out_stage
  import opt_pkg::*;
#(
  parameter int RANK_W = 1,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [RANK_W-1:0] rank_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              write_i,
  input  need_e             need_i,
  output logic              vld_o,
  output logic [RANK_W-1:0] rank_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              write_o,
  output need_e             need_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= vld_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rank_o  <= '0;
      bank_o  <= '0;
      row_o   <= '0;
      col_o   <= '0;
      write_o <= 1'b0;
      need_o  <= NEED_NONE;
    end else if (vld_i) begin
      rank_o  <= rank_i;
      bank_o  <= bank_i;
      row_o   <= row_i;
      col_o   <= col_i;
      write_o <= write_i;
      need_o  <= need_i;
    end
  end
endmodule

// File: rtl/open_page_tracker.sv
module open_page_tracker
  import opt_pkg::*;
#(
  parameter int RANKS  = 2,
  parameter int BANKS  = 2,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [RANK_W-1:0] req_rank_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_write_i,
  input  logic              ntc_act_i,
  input  logic              ntc_pre_i,
  input  logic              ntc_pre_all_i,
  input  logic [RANK_W-1:0] ntc_rank_i,
  input  logic [BANK_W-1:0] ntc_bank_i,
  input  logic [ROW_W-1:0]  ntc_row_i,
  output logic              out_valid_o,
  output logic [RANK_W-1:0] out_rank_o,
  output logic [BANK_W-1:0] out_bank_o,
  output logic [ROW_W-1:0]  out_row_o,
  output logic [COL_W-1:0]  out_col_o,
  output logic              out_write_o,
  output logic [1:0]        out_need_o
);
  localparam int ENTRIES = RANKS * BANKS;
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [IDX_W-1:0] req_idx, ntc_idx;
  logic             lkp_open;
  logic [ROW_W-1:0] lkp_row;
  need_e            need_d, need_q;

  assign req_idx = IDX_W'(int'(req_rank_i) * BANKS + int'(req_bank_i));
  assign ntc_idx = IDX_W'(int'(ntc_rank_i) * BANKS + int'(ntc_bank_i));

  opt_page_table #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .ROW_W(ROW_W)
  ) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (ntc_act_i),
    .pre_i       (ntc_pre_i),
    .pre_all_i   (ntc_pre_all_i),
    .upd_idx_i   (ntc_idx),
    .upd_row_i   (ntc_row_i),
    .lkp_idx_i   (req_idx),
    .lkp_valid_o (lkp_open),
    .lkp_row_o   (lkp_row)
  );

  opt_classify #(.ROW_W(ROW_W)) u_cls (
    .open_i     (lkp_open),
    .open_row_i (lkp_row),
    .req_row_i  (req_row_i),
    .need_o     (need_d)
  );

  opt_out_stage #(
    .RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (req_valid_i),
    .rank_i  (req_rank_i),
    .bank_i  (req_bank_i),
    .row_i   (req_row_i),
    .col_i   (req_col_i),
    .write_i (req_write_i),
    .need_i  (need_d),
    .vld_o   (out_valid_o),
    .rank_o  (out_rank_o),
    .bank_o  (out_bank_o),
    .row_o   (out_row_o),
    .col_o   (out_col_o),
    .write_o (out_write_o),
    .need_o  (need_q)
  );

  assign out_need_o = need_q;
endmodule

// File: rtl/open_page_tracker_chk.sv
module open_page_tracker_chk #(
  parameter int RANK_W = 1,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [RANK_W-1:0] req_rank_i,
  input logic [BANK_W-1:0] req_bank_i,
  input logic [ROW_W-1:0]  req_row_i,
  input logic [COL_W-1:0]  req_col_i,
  input logic              ntc_act_i,
  input logic              ntc_pre_i,
  input logic              ntc_pre_all_i,
  input logic [RANK_W-1:0] ntc_rank_i,
  input logic [BANK_W-1:0] ntc_bank_i,
  input logic [ROW_W-1:0]  ntc_row_i,
  input logic              out_valid_o,
  input logic [ROW_W-1:0]  out_row_o,
  input logic [COL_W-1:0]  out_col_o,
  input logic [1:0]        out_need_o
);
  logic same_bank;
  assign same_bank = (req_rank_i == ntc_rank_i) && (req_bank_i == ntc_bank_i);

  always_comb begin
    if (!rst_ni) assert_reset_idle_R1: assert (out_valid_o == 1'b0);
  end

  assert_valid_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> out_valid_o);
  assert_idle_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !out_valid_o);
  assert_fields_fwd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (out_row_o == $past(req_row_i)) && (out_col_o == $past(req_col_i)));
  assert_pre_all_closes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ntc_pre_all_i && !ntc_act_i) |=> out_need_o == 2'b01);
  assert_bypass_act_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ntc_act_i && same_bank && req_row_i == ntc_row_i) |=> out_need_o == 2'b00);
  assert_bypass_pre_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ntc_pre_i && !ntc_act_i && same_bank) |=> out_need_o == 2'b01);
  assert_legal_need_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_need_o != 2'b10);
endmodule

bind open_page_tracker open_page_tracker_chk #(
  .RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_rank_i    (req_rank_i),
  .req_bank_i    (req_bank_i),
  .req_row_i     (req_row_i),
  .req_col_i     (req_col_i),
  .ntc_act_i     (ntc_act_i),
  .ntc_pre_i     (ntc_pre_i),
  .ntc_pre_all_i (ntc_pre_all_i),
  .ntc_rank_i    (ntc_rank_i),
  .ntc_bank_i    (ntc_bank_i),
  .ntc_row_i     (ntc_row_i),
  .out_valid_o   (out_valid_o),
  .out_row_o     (out_row_o),
  .out_col_o     (out_col_o),
  .out_need_o    (out_need_o)
);

// File: tb/tb_open_page_tracker.sv
module tb_open_page_tracker;
  localparam int RANK_W = 1;
  localparam int BANK_W = 1;
  localparam int ROW_W  = 14;
  localparam int COL_W  = 10;
  localparam logic [1:0] N_NONE = 2'b00, N_ACT = 2'b01, N_PA = 2'b11;

  logic clk = 0, rst_ni = 0;
  logic req_valid = 0, req_write = 0;
  logic [RANK_W-1:0] req_rank = '0, ntc_rank = '0, out_rank;
  logic [BANK_W-1:0] req_bank = '0, ntc_bank = '0, out_bank;
  logic [ROW_W-1:0]  req_row = '0, ntc_row = '0, out_row;
  logic [COL_W-1:0]  req_col = '0, out_col;
  logic ntc_act = 0, ntc_pre = 0, ntc_pre_all = 0;
  logic out_valid, out_write;
  logic [1:0] out_need;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  open_page_tracker dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_rank_i(req_rank), .req_bank_i(req_bank),
    .req_row_i(req_row), .req_col_i(req_col), .req_write_i(req_write),
    .ntc_act_i(ntc_act), .ntc_pre_i(ntc_pre), .ntc_pre_all_i(ntc_pre_all),
    .ntc_rank_i(ntc_rank), .ntc_bank_i(ntc_bank), .ntc_row_i(ntc_row),
    .out_valid_o(out_valid), .out_rank_o(out_rank), .out_bank_o(out_bank),
    .out_row_o(out_row), .out_col_o(out_col), .out_write_o(out_write),
    .out_need_o(out_need)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_req(input int rk, input int bk, input int row, input int col, input bit wr);
    req_valid = 1; req_rank = RANK_W'(rk); req_bank = BANK_W'(bk);
    req_row = ROW_W'(row); req_col = COL_W'(col); req_write = wr;
  endtask

  task automatic set_ntc(input bit a, input bit p, input bit pa, input int rk, input int bk, input int row);
    ntc_act = a; ntc_pre = p; ntc_pre_all = pa;
    ntc_rank = RANK_W'(rk); ntc_bank = BANK_W'(bk); ntc_row = ROW_W'(row);
  endtask

  task automatic clear_in();
    req_valid = 0; ntc_act = 0; ntc_pre = 0; ntc_pre_all = 0;
  endtask

  // called at a falling edge; result read one edge later
  task automatic lookup(input int rk, input int bk, input int row, input logic [1:0] exp, input string req);
    set_req(rk, bk, row, 0, 0);
    @(negedge clk);
    clear_in();
    chk(out_valid == 1'b1, req, 32'(out_valid), 1);
    chk(out_need == exp, req, 32'(out_need), 32'(exp));
  endtask

  task automatic notice(input bit a, input bit p, input bit pa, input int rk, input int bk, input int row);
    set_ntc(a, p, pa, rk, bk, row);
    @(negedge clk);
    clear_in();
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", 32'(out_valid), 0);
    rst_ni = 1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", 32'(out_valid), 0);
    for (int e = 0; e < 4; e++) lookup(e / 2, e % 2, 16'h55, N_ACT, "R1 R3 closed after reset");
    lookup(0, 0, 16'h55, N_ACT, "R6 lookup leaves table");
  endtask

  task automatic t_forward();
    set_req(1, 0, 14'h2a5c, 10'h3c1, 1);
    @(negedge clk);
    clear_in();
    chk(out_valid == 1'b1, "R2 valid", 32'(out_valid), 1);
    chk(out_rank == 1'b1 && out_bank == 1'b0, "R2 rank/bank", {out_rank, out_bank}, 2'b10);
    chk(out_row == 14'h2a5c, "R2 row", 32'(out_row), 32'h2a5c);
    chk(out_col == 10'h3c1, "R2 col", 32'(out_col), 32'h3c1);
    chk(out_write == 1'b1, "R2 write", 32'(out_write), 1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 idle", 32'(out_valid), 0);
  endtask

  task automatic t_hit_conflict();
    notice(1, 0, 0, 0, 1, 14'h123);
    lookup(0, 1, 14'h123, N_NONE, "R4 R7 hit after activate");
    lookup(0, 1, 14'h124, N_PA, "R5 conflict");
    lookup(0, 1, 14'h124, N_PA, "R6 conflict unchanged");
    lookup(0, 0, 14'h123, N_ACT, "R7 neighbour bank closed");
    lookup(1, 1, 14'h123, N_ACT, "R7 other rank closed");
    notice(0, 1, 0, 0, 1, 0);
    lookup(0, 1, 14'h123, N_ACT, "R7 precharge closes");
  endtask

  task automatic t_pre_all();
    for (int e = 0; e < 4; e++) notice(1, 0, 0, e / 2, e % 2, 14'h100 + e);
    for (int e = 0; e < 4; e++) lookup(e / 2, e % 2, 14'h100 + e, N_NONE, "R7 all open");
    notice(0, 0, 1, 0, 0, 0);
    for (int e = 0; e < 4; e++) lookup(e / 2, e % 2, 14'h100 + e, N_ACT, "R8 all closed");
  endtask

  task automatic t_bypass();
    set_ntc(1, 0, 0, 1, 0, 14'h77);
    set_req(1, 0, 14'h77, 0, 0);
    @(negedge clk);
    clear_in();
    chk(out_need == N_NONE, "R9 activate bypass", 32'(out_need), 32'(N_NONE));
    set_ntc(0, 1, 0, 1, 0, 0);
    set_req(1, 0, 14'h77, 0, 0);
    @(negedge clk);
    clear_in();
    chk(out_need == N_ACT, "R9 precharge bypass", 32'(out_need), 32'(N_ACT));
    notice(1, 0, 0, 1, 1, 14'h9);
    set_ntc(0, 0, 1, 0, 0, 0);
    set_req(1, 1, 14'h9, 0, 0);
    @(negedge clk);
    clear_in();
    chk(out_need == N_ACT, "R9 precharge-all bypass", 32'(out_need), 32'(N_ACT));
  endtask

  task automatic t_act_wins();
    notice(1, 0, 0, 0, 0, 14'h11);
    notice(1, 0, 0, 1, 1, 14'h22);
    notice(1, 0, 1, 0, 0, 14'h33);
    lookup(0, 0, 14'h33, N_NONE, "R10 activate beats precharge-all");
    lookup(1, 1, 14'h22, N_ACT, "R10 precharge-all closes others");
    notice(1, 1, 0, 0, 1, 14'h44);
    lookup(0, 1, 14'h44, N_NONE, "R10 activate beats precharge");
  endtask

  initial begin
    t_reset();
    t_forward();
    t_hit_conflict();
    t_pre_all();
    t_bypass();
    t_act_wins();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule